// File: doc/BRIEF.md
# GHASH Authentication Engine with Digit-Serial GF(2^128) Multiplier

This engine computes the GCM authentication hash over a stream of 128-bit blocks and turns it into the final tag. A 128-bit hash key is loaded first. Each block that the engine accepts is XORed into a running accumulator. The sum is then multiplied by the hash key in GF(2^128). The blocks must arrive in a fixed order: associated-data blocks first, then ciphertext blocks, then one length block. Once the length block has been absorbed, the engine XORs the accumulator with the enciphered initial counter block and presents the result as the tag.

The multiplier is digit-serial. In each cycle it consumes 12 bits of the accumulated operand against the full 128-bit key. One product therefore takes 11 cycles, and the last digit carries only 8 real bits. While a product is in progress `busy` is high, and every block, key load or message start offered in that time is ignored. The surrounding logic presents the next block only after `busy` falls. It can run the counter-mode encryption of the next block during those 11 cycles.

Top module: `ghash_engine`

## Requirements
- R1: After reset, `busy` and `tagValid` are 0 and `tagOut` is all zeros.
- R2: When the engine is idle, `hkeyLoad` captures `hkeyIn` as the hash key. A `hkeyLoad` that arrives while `busy` is high has no effect.
- R3: Each accepted block updates the accumulator to (acc XOR blkData)·H in GF(2^128), reduced by x^128+x^7+x^2+x+1. Bit 127 of a bus holds the coefficient of x^0 and bit 0 holds the coefficient of x^127.
- R4: After the clock edge that accepts a block, `busy` stays high for exactly 11 cycles, which is ceil(128/12).
- R5: A block offered while `busy` is high is ignored and does not change the result.
- R6: `blkType` is encoded 0 = associated data, 1 = ciphertext, 2 = length and 3 = reserved. A reserved block is ignored. A block whose type is lower than the type of the last accepted block is ignored. After a length block, every block is ignored until the next message start.
- R7: When the product for the length block completes, `tagOut` becomes the final hash XOR the value of `ekj0In` that was sampled together with the length block. `tagValid` rises in the same cycle that `busy` falls and stays high until the next message start.
- R8: A `startMsg` pulse while the engine is idle clears the accumulator, the block order and `tagValid`. It takes precedence over a block offered in the same cycle, and that block is ignored.
- R9: A message may contain no associated data or no ciphertext. Its tag is then the hash of the blocks actually given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hkeyLoad | input | 1 | Load the hash key (idle only) |
| hkeyIn | input | 128 | Hash key H |
| startMsg | input | 1 | Begin a new message (idle only) |
| blkValid | input | 1 | Block offered this cycle |
| blkType | input | 2 | Block type: 0 associated data, 1 ciphertext, 2 length, 3 reserved |
| blkData | input | 128 | Block contents |
| ekj0In | input | 128 | Enciphered initial counter block, sampled with the length block |
| busy | output | 1 | A multiplication is in progress |
| tagValid | output | 1 | The tag of the current message is ready |
| tagOut | output | 128 | Authentication tag |

## Verification
The assertions assume that `startMsg` is given only as a pulse between messages. They also assume that the surrounding logic does not rely on inputs given during `busy`. The checks on busy length and block order take for granted that a message starts with `startMsg` after reset.

The stimulus waits for `busy` to fall before it offers the next real block. It injects blocks and key loads during `busy` only on purpose, to show that they are ignored. Block types, counts and data are drawn from a seeded generator within the legal order. A few directed cases then break that order on purpose.

// File: rtl/ghash_pkg.sv
package ghash_pkg;
  localparam int BLK_W_DEF = 128;
  localparam int DIG_W_DEF = 12;

  typedef enum logic [1:0] {
    BT_AAD = 2'd0,
    BT_CT  = 2'd1,
    BT_LEN = 2'd2,
    BT_RSV = 2'd3
  } blk_type_e;

  typedef struct packed {
    logic loadKey;
    logic clearMsg;
    logic startMul;
    logic stepMul;
    logic finishMul;
    logic captureJ0;
    logic makeTag;
  } ghash_strobe_t;
endpackage

// File: rtl/ghash_gfmul_digit.sv
module ghash_gfmul_digit #(
  parameter int BLK_W = 128,
  parameter int DIG_W = 12
) (
  input  logic [BLK_W-1:0] zIn,
  input  logic [BLK_W-1:0] vIn,
  input  logic [DIG_W-1:0] digit,
  output logic [BLK_W-1:0] zOut,
  output logic [BLK_W-1:0] vOut
);
  localparam logic [BLK_W-1:0] RED = {8'hE1, {(BLK_W-8){1'b0}}};

  logic [BLK_W-1:0] zAcc;
  logic [BLK_W-1:0] vAcc;

  // digit is consumed MSB first; each bit is one coefficient of the operand
  always_comb begin
    zAcc = zIn;
    vAcc = vIn;
    for (int i = 0; i < DIG_W; i++) begin
      if (digit[DIG_W-1-i]) zAcc = zAcc ^ vAcc;
      vAcc = vAcc[0] ? ((vAcc >> 1) ^ RED) : (vAcc >> 1);
    end
  end

  assign zOut = zAcc;
  assign vOut = vAcc;
endmodule

// File: rtl/ghash_datapath.sv
module ghash_datapath
  import ghash_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int DIG_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  ghash_strobe_t       st,
  input  logic [BLK_W-1:0]    hkeyIn,
  input  logic [BLK_W-1:0]    blkData,
  input  logic [BLK_W-1:0]    ekj0In,
  output logic [BLK_W-1:0]    tagOut
);
  localparam int DIGITS = (BLK_W + DIG_W - 1) / DIG_W;
  localparam int OP_W   = DIGITS * DIG_W;
  localparam int PAD    = OP_W - BLK_W;

  logic [BLK_W-1:0] hKey, acc, zReg, vReg, j0Reg, tagReg;
  logic [OP_W-1:0]  opX;
  logic [BLK_W-1:0] zNext, vNext;

  ghash_gfmul_digit #(.BLK_W(BLK_W), .DIG_W(DIG_W)) u_digit (
    .zIn  (zReg),
    .vIn  (vReg),
    .digit(opX[OP_W-1 -: DIG_W]),
    .zOut (zNext),
    .vOut (vNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hKey   <= '0;
      acc    <= '0;
      zReg   <= '0;
      vReg   <= '0;
      j0Reg  <= '0;
      tagReg <= '0;
      opX    <= '0;
    end else begin
      if (st.loadKey)   hKey  <= hkeyIn;
      if (st.captureJ0) j0Reg <= ekj0In;
      if (st.startMul) begin
        opX  <= {acc ^ blkData, {PAD{1'b0}}};
        zReg <= '0;
        vReg <= hKey;
      end else if (st.stepMul) begin
        opX  <= opX << DIG_W;
        zReg <= zNext;
        vReg <= vNext;
      end
      if (st.clearMsg)       acc <= '0;
      else if (st.finishMul) acc <= zNext;
      if (st.clearMsg)     tagReg <= '0;
      else if (st.makeTag) tagReg <= zNext ^ j0Reg;
    end
  end

  assign tagOut = tagReg;

  // R3: a product never starts and steps in the same cycle
  a_r3_start_excl_step: assert property (@(posedge clk) disable iff (!rstN)
    st.startMul |-> !st.stepMul);
  // R7: the tag is formed only on the completing step of a product
  a_r7_tag_on_finish: assert property (@(posedge clk) disable iff (!rstN)
    st.makeTag |-> (st.finishMul && st.stepMul));
endmodule

// File: rtl/ghash_ctrl.sv
module ghash_ctrl
  import ghash_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int DIG_W = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hkeyLoad,
  input  logic          startMsg,
  input  logic          blkValid,
  input  logic [1:0]    blkType,
  output ghash_strobe_t st,
  output logic          busy,
  output logic          tagValid
);
  localparam int DIGITS = (BLK_W + DIG_W - 1) / DIG_W;
  localparam int CNT_W  = $clog2(DIGITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIGITS - 1);

  logic             busyQ, isLenQ, tagValidQ;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       phaseQ;
  logic             idle, startOk, accept, lastStep;

  assign idle     = !busyQ;
  assign startOk  = idle && startMsg;
  assign accept   = idle && !startMsg && blkValid &&
                    (blkType != BT_RSV) && (blkType >= phaseQ);
  assign lastStep = busyQ && (cnt == LAST);

  always_comb begin
    st           = '0;
    st.loadKey   = idle && hkeyLoad;
    st.clearMsg  = startOk;
    st.startMul  = accept;
    st.captureJ0 = accept && (blkType == BT_LEN);
    st.stepMul   = busyQ;
    st.finishMul = lastStep;
    st.makeTag   = lastStep && isLenQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      isLenQ    <= 1'b0;
      tagValidQ <= 1'b0;
      cnt       <= '0;
      phaseQ    <= BT_AAD;
    end else if (busyQ) begin
      cnt <= cnt + 1'b1;
      if (lastStep) begin
        busyQ <= 1'b0;
        if (isLenQ) tagValidQ <= 1'b1;
      end
    end else if (startOk) begin
      phaseQ    <= BT_AAD;
      tagValidQ <= 1'b0;
    end else if (accept) begin
      busyQ  <= 1'b1;
      cnt    <= '0;
      isLenQ <= (blkType == BT_LEN);
      phaseQ <= (blkType == BT_LEN) ? 2'd3 : blkType;
    end
  end

  assign busy     = busyQ;
  assign tagValid = tagValidQ;

  // R4: the digit count never runs past the last digit
  a_r4_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (cnt <= LAST));
  // R5: busy only begins from an idle cycle with a block on offer
  a_r5_busy_from_offer: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(blkValid && !busyQ));
  // R6: block order only moves backwards through a message start
  a_r6_order_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ < $past(phaseQ)) |-> $past(startMsg));
  // R7: the tag only becomes valid as a multiplication ends
  a_r7_tag_after_mul: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tagValidQ) |-> ($past(busyQ) && !busyQ));
endmodule

// File: rtl/ghash_engine.sv
module ghash_engine
  import ghash_pkg::*;
#(
  parameter int BLK_W = BLK_W_DEF,
  parameter int DIG_W = DIG_W_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hkeyLoad,
  input  logic [BLK_W-1:0] hkeyIn,
  input  logic             startMsg,
  input  logic             blkValid,
  input  logic [1:0]       blkType,
  input  logic [BLK_W-1:0] blkData,
  input  logic [BLK_W-1:0] ekj0In,
  output logic             busy,
  output logic             tagValid,
  output logic [BLK_W-1:0] tagOut
);
  ghash_strobe_t st;

  ghash_ctrl #(.BLK_W(BLK_W), .DIG_W(DIG_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hkeyLoad(hkeyLoad),
    .startMsg(startMsg),
    .blkValid(blkValid),
    .blkType (blkType),
    .st      (st),
    .busy    (busy),
    .tagValid(tagValid)
  );

  ghash_datapath #(.BLK_W(BLK_W), .DIG_W(DIG_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .hkeyIn (hkeyIn),
    .blkData(blkData),
    .ekj0In (ekj0In),
    .tagOut (tagOut)
  );
endmodule

// File: tb/ghash_engine_bench.sv
`timescale 1ns/1ps
module ghash_engine_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         hkeyLoad = 1'b0, startMsg = 1'b0, blkValid = 1'b0;
  logic [127:0] hkeyIn = '0, blkData = '0, ekj0In = '0;
  logic [1:0]   blkType = '0;
  logic         busy, tagValid;
  logic [127:0] tagOut;

  int total = 0;
  int bad = 0;

  // bench model state
  logic [127:0] mH, mAcc, mJ0;
  int           mPhase;

  always #2.5 clk = ~clk;

  ghash_engine u_ghash_engine (
    .clk(clk), .rstN(rstN), .hkeyLoad(hkeyLoad), .hkeyIn(hkeyIn),
    .startMsg(startMsg), .blkValid(blkValid), .blkType(blkType),
    .blkData(blkData), .ekj0In(ekj0In), .busy(busy),
    .tagValid(tagValid), .tagOut(tagOut));

  function automatic logic [127:0] gfmulRef(input logic [127:0] x, input logic [127:0] y);
    logic [127:0] z = '0;
    logic [127:0] v = y;
    for (int i = 0; i < 128; i++) begin
      if (x[127-i]) z ^= v;
      v = v[0] ? ((v >> 1) ^ {8'hE1, 120'b0}) : (v >> 1);
    end
    return z;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadKey(input logic [127:0] k);
    @(negedge clk); hkeyLoad = 1'b1; hkeyIn = k;
    @(negedge clk); hkeyLoad = 1'b0;
    mH = k;
  endtask

  task automatic beginMsg(input bit withBlk);
    @(negedge clk); startMsg = 1'b1;
    if (withBlk) begin blkValid = 1'b1; blkType = 2'd0; blkData = rnd128(); end
    @(negedge clk); startMsg = 1'b0; blkValid = 1'b0;
    if (withBlk) chk(busy == 1'b0, "R8 start beats block", 128'(busy), 128'd0);
    mAcc = '0; mPhase = 0;
  endtask

  // offer one block; intrude=1 injects a junk block and key load during busy
  task automatic sendBlk(input logic [1:0] t, input logic [127:0] d, input bit intrude);
    bit acc = (t != 2'd3) && (int'(t) >= mPhase);
    int cnt = 0;
    @(negedge clk); blkValid = 1'b1; blkType = t; blkData = d;
    if (t == 2'd2) ekj0In = mJ0;
    @(negedge clk); blkValid = 1'b0;
    if (acc) begin
      while (busy && cnt < 40) begin
        if (intrude && cnt == 3) begin
          blkValid = 1'b1; blkType = 2'd1; blkData = rnd128();
          hkeyLoad = 1'b1; hkeyIn = rnd128();
        end else begin
          blkValid = 1'b0; hkeyLoad = 1'b0;
        end
        cnt++;
        @(negedge clk);
      end
      blkValid = 1'b0; hkeyLoad = 1'b0;
      chk(cnt == 11, "R4 busy length", 128'(cnt), 128'd11);
      mAcc = gfmulRef(mAcc ^ d, mH);
      mPhase = (t == 2'd2) ? 3 : int'(t);
    end else begin
      chk(busy == 1'b0, "R6 block ignored", 128'(busy), 128'd0);
    end
  endtask

  task automatic finishMsg(input string req);
    mJ0 = rnd128();
    sendBlk(2'd2, rnd128(), 1'b0);
    chk(tagValid == 1'b1, {req, " tagValid"}, 128'(tagValid), 128'd1);
    chk(tagOut == (mAcc ^ mJ0), {req, " tag"}, tagOut, mAcc ^ mJ0);
  endtask

  task automatic randMsg(input int nA, input int nC, input bit intrude, input string req);
    beginMsg(1'b0);
    for (int i = 0; i < nA; i++) sendBlk(2'd0, rnd128(), intrude);
    for (int i = 0; i < nC; i++) sendBlk(2'd1, rnd128(), intrude);
    finishMsg(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] a, l;
    void'($urandom(32'd20240611));
    mH = '0; mAcc = '0; mJ0 = '0; mPhase = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", 128'(busy), 128'd0);
    chk(tagValid == 1'b0, "R1 tagValid", 128'(tagValid), 128'd0);
    chk(tagOut == '0, "R1 tagOut", tagOut, 128'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 directed: H = 1 (x^0 is bit 127), tag = A ^ L ^ J0
    loadKey({1'b1, 127'b0});
    beginMsg(1'b0);
    a = rnd128(); l = rnd128();
    sendBlk(2'd0, a, 1'b0);
    mJ0 = '0;
    sendBlk(2'd2, l, 1'b0);
    chk(tagOut == (a ^ l), "R3 identity key", tagOut, a ^ l);

    // R3 directed: H = x, single block 1 -> x (bit 126)
    loadKey({2'b01, 126'b0});
    beginMsg(1'b0);
    sendBlk(2'd0, {1'b1, 127'b0}, 1'b0);
    mJ0 = '0;
    sendBlk(2'd2, '0, 1'b0);
    // acc = x*x^... : (x)*H then (x ^ 0)*H = x^2
    chk(tagOut == {3'b001, 125'b0}, "R3 x squared", tagOut, {3'b001, 125'b0});

    // R3 x^127 * x wraps through the reduction polynomial
    loadKey({2'b01, 126'b0});
    beginMsg(1'b0);
    mJ0 = '0;
    sendBlk(2'd0, 128'd1, 1'b0);
    chk(busy == 1'b0, "R3 idle", 128'(busy), 128'd0);
    sendBlk(2'd2, 128'd1, 1'b0);
    chk(tagOut == gfmulRef(gfmulRef(128'd1, mH) ^ 128'd1, mH), "R3 wrap",
        tagOut, gfmulRef(gfmulRef(128'd1, mH) ^ 128'd1, mH));

    // R7 zero key: tag equals J0
    loadKey('0);
    randMsg(1, 1, 1'b0, "R7 zero key");
    chk(tagOut == mJ0, "R7 tag is J0", tagOut, mJ0);

    // R3 R7 random messages, R9 empty sections
    loadKey(rnd128());
    randMsg(2, 3, 1'b0, "R3 random");
    randMsg(0, 2, 1'b0, "R9 no aad");
    randMsg(3, 0, 1'b0, "R9 no ct");
    randMsg(0, 0, 1'b0, "R9 length only");
    for (int k = 0; k < 6; k++) begin
      loadKey(rnd128());
      randMsg(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), 1'b0, "R3 random");
    end

    // R2 R5 intrusions during busy ignored
    loadKey(rnd128());
    randMsg(2, 2, 1'b1, "R5 R2 intrude");

    // R6 out-of-order and reserved blocks ignored
    beginMsg(1'b0);
    sendBlk(2'd1, rnd128(), 1'b0);
    sendBlk(2'd0, rnd128(), 1'b0);
    sendBlk(2'd3, rnd128(), 1'b0);
    finishMsg("R6 order");
    sendBlk(2'd1, rnd128(), 1'b0);
    chk(tagOut == (mAcc ^ mJ0), "R6 after length", tagOut, mAcc ^ mJ0);

    // R8 start clears tagValid and beats a simultaneous block
    beginMsg(1'b1);
    chk(tagValid == 1'b0, "R8 tagValid cleared", 128'(tagValid), 128'd0);
    chk(tagOut == '0, "R8 tag cleared", tagOut, 128'd0);
    sendBlk(2'd0, rnd128(), 1'b0);
    finishMsg("R8 fresh acc");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule